// File: doc/BRIEF.md
# Keyboard Two-Digit Entry Adder

This block sits behind a keyboard receiver that has already turned serial traffic into byte scancodes. Each keystroke arrives as a scancode held steady alongside a key-event strobe, and that strobe may stay high for one clock or for many. The block acts once on each rising edge of the strobe. It translates the scancode into a decimal digit and steers the digit into one of two operand registers. The first digit goes into operand A, the next into operand B, and the one after that goes back into A.

Both operands are visible at the ports. A registered 4-bit sum with carry-out follows them, so a user can key in two digits and read the result one clock after the second digit lands. The plus key and any scancode that is not a digit are dropped without touching the operands or the position in the A/B sequence.

Top module: `kbd_digit_adder`

## Requirements
- R1: The digit scancodes decode as 0x45→0, 0x16→1, 0x1E→2, 0x26→3, 0x25→4, 0x2E→5, 0x36→6, 0x3D→7, 0x3E→8 and 0x46→9. Each loaded operand equals the value decoded from the scancode present at the event edge, so no operand ever exceeds 9.
- R2: A digit is captured only on a clock where the key-event input is 1 and was 0 on the previous clock. Holding the event high for more clocks, even while the scancode changes, loads nothing further.
- R3: Successive digit events alternate between the two operands: the first after reset loads A, the second loads B, the third loads A again, and so on.
- R4: Loading A leaves B unchanged, and loading B leaves A unchanged.
- R5: The plus-key scancode 0x55 changes neither operand and does not advance the A/B sequence.
- R6: Any scancode outside the digit set and 0x55 changes neither operand and does not advance the A/B sequence.
- R7: {carry_out, sum} equals A + B as a 4-bit ripple-carry addition with a carry-in of 0. For example, 9 + 9 gives sum 0010 with carry_out 1.
- R8: sum and carry_out are registered. They reflect the operands one clock after those operands change.
- R9: A synchronous active-high reset clears A, B, sum, carry_out and the stored event level, and it returns the sequence to loading A next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_code | input | 8 | Scancode of the current key, valid while key_evt is high |
| key_evt | input | 1 | Key-event strobe; its rising edge marks a keystroke |
| opnd_a | output | 4 | Operand A, first digit of each pair |
| opnd_b | output | 4 | Operand B, second digit of each pair |
| sum | output | 4 | Registered low 4 bits of A + B |
| carry_out | output | 1 | Registered carry out of A + B |

## Verification
A corrupted A/B index shows up at the operand ports on the very next digit event, because the digit lands in the wrong register. A stored event level that fails to track the input shows up within one clock of a held strobe, as a reload or a missed load. A fault in the adder chain or in its register shows at sum or carry_out one clock after an operand changes. The bench therefore compares every operand and result port after each keystroke, and this includes the ignored keys and held strobes.

// File: rtl/kda_pkg.sv
package kda_pkg;

    localparam int SCAN_W  = 8;
    localparam int DIGIT_W = 4;

    typedef logic [SCAN_W-1:0]  scan_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        KEY_NONE  = 2'd0,
        KEY_DIGIT = 2'd1,
        KEY_PLUS  = 2'd2
    } key_kind_e;

    typedef struct packed {
        key_kind_e kind;
        digit_t    value;
    } key_info_t;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    typedef struct packed {
        digit_t a;
        digit_t b;
    } operands_t;

    typedef struct packed {
        logic   carry;
        digit_t sum;
    } result_t;

    localparam scan_t PLUS_CODE = 8'h55;

    // Map a scancode onto a key class and, for digits, its decimal value.
    function automatic key_info_t classify_scan(input scan_t code);
        key_info_t info;
        info.kind  = KEY_DIGIT;
        info.value = '0;
        case (code)
            8'h45: info.value = 4'd0;
            8'h16: info.value = 4'd1;
            8'h1E: info.value = 4'd2;
            8'h26: info.value = 4'd3;
            8'h25: info.value = 4'd4;
            8'h2E: info.value = 4'd5;
            8'h36: info.value = 4'd6;
            8'h3D: info.value = 4'd7;
            8'h3E: info.value = 4'd8;
            8'h46: info.value = 4'd9;
            PLUS_CODE: info.kind = KEY_PLUS;
            default:   info.kind = KEY_NONE;
        endcase
        return info;
    endfunction

    // One bit of a ripple adder: returns {carry, sum}.
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
        return {(x & y) | (cin & (x ^ y)), x ^ y ^ cin};
    endfunction

endpackage

// File: rtl/kda_key_edge.sv
module kda_key_edge (
    input  logic clk,
    input  logic rst,
    input  logic evt_in,
    output logic evt_rise
);
    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_in;
        end
    end

    assign evt_rise = evt_in & ~evt_q;
endmodule

// File: rtl/kda_scan_decode.sv
module kda_scan_decode
    import kda_pkg::*;
(
    input  scan_t  scan_in,
    input  logic   evt_rise,
    output logic   digit_stb,
    output digit_t digit_val
);
    key_info_t info;

    always_comb begin
        info      = classify_scan(scan_in);
        digit_stb = evt_rise && (info.kind == KEY_DIGIT);
        digit_val = info.value;
    end
endmodule

// File: rtl/kda_operand_seq.sv
module kda_operand_seq
    import kda_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      digit_stb,
    input  digit_t    digit_val,
    output operands_t opnds
);
    slot_e     slot_q;
    operands_t opnds_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_A;
            opnds_q <= '0;
        end else if (digit_stb) begin
            if (slot_q == SLOT_A) begin
                opnds_q.a <= digit_val;
                slot_q    <= SLOT_B;
            end else begin
                opnds_q.b <= digit_val;
                slot_q    <= SLOT_A;
            end
        end
    end

    assign opnds = opnds_q;
endmodule

// File: rtl/kda_sum_reg.sv
module kda_sum_reg
    import kda_pkg::*;
#(
    parameter int WIDTH = DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum_q,
    output logic             carry_q
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sum_d;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] fa;
        assign fa         = full_add(x[i], y[i], chain[i]);
        assign sum_d[i]   = fa[0];
        assign chain[i+1] = fa[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= sum_d;
            carry_q <= chain[WIDTH];
        end
    end
endmodule

// File: rtl/kbd_digit_adder.sv
module kbd_digit_adder
    import kda_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] scan_code,
    input  logic       key_evt,
    output logic [3:0] opnd_a,
    output logic [3:0] opnd_b,
    output logic [3:0] sum,
    output logic       carry_out
);
    logic      evt_rise;
    logic      digit_stb;
    digit_t    digit_val;
    operands_t opnds;

    kda_key_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (key_evt),
        .evt_rise (evt_rise)
    );

    kda_scan_decode u_decode (
        .scan_in   (scan_code),
        .evt_rise  (evt_rise),
        .digit_stb (digit_stb),
        .digit_val (digit_val)
    );

    kda_operand_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .digit_stb (digit_stb),
        .digit_val (digit_val),
        .opnds     (opnds)
    );

    kda_sum_reg #(.WIDTH(DIGIT_W)) u_add (
        .clk     (clk),
        .rst     (rst),
        .x       (opnds.a),
        .y       (opnds.b),
        .cin     (1'b0),
        .sum_q   (sum),
        .carry_q (carry_out)
    );

    assign opnd_a = opnds.a;
    assign opnd_b = opnds.b;
endmodule

// File: rtl/kbd_digit_adder_checker.sv
module kbd_digit_adder_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] scan_code,
    input logic       key_evt,
    input logic [3:0] opnd_a,
    input logic [3:0] opnd_b,
    input logic [3:0] sum,
    input logic       carry_out
);
    p_digit_range_r1: assert property (@(posedge clk) disable iff (rst)
        (opnd_a <= 4'd9) && (opnd_b <= 4'd9));

    p_held_no_load_r2: assert property (@(posedge clk) disable iff (rst)
        (key_evt && $past(key_evt) && !$past(rst))
        |=> ($stable(opnd_a) && $stable(opnd_b)));

    p_one_operand_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(opnd_a) |-> $stable(opnd_b));

    p_plus_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (key_evt && !$past(key_evt) && scan_code == 8'h55)
        |=> ($stable(opnd_a) && $stable(opnd_b)));

    p_sum_r7_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({carry_out, sum} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (opnd_a == 4'd0 && opnd_b == 4'd0 && sum == 4'd0 && !carry_out));
endmodule

bind kbd_digit_adder kbd_digit_adder_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_code (scan_code),
    .key_evt   (key_evt),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/kbd_digit_adder_bench.sv
module kbd_digit_adder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] scan_code = 8'h00;
    logic       key_evt = 1'b0;
    logic [3:0] opnd_a, opnd_b, sum;
    logic       carry_out;

    typedef struct {
        logic [3:0] a;
        logic [3:0] b;
        logic [4:0] res;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic [3:0] m_a = 0, m_b = 0;
    logic       m_slot_b = 1'b0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    kbd_digit_adder u_kbd_digit_adder (
        .clk(clk), .rst(rst), .scan_code(scan_code), .key_evt(key_evt),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sum(sum), .carry_out(carry_out)
    );

    function automatic int digit_of(input logic [7:0] c);
        case (c)
            8'h45: return 0;  8'h16: return 1;  8'h1E: return 2;
            8'h26: return 3;  8'h25: return 4;  8'h2E: return 5;
            8'h36: return 6;  8'h3D: return 7;  8'h3E: return 8;
            8'h46: return 9;
            default: return -1;
        endcase
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        e.a = m_a; e.b = m_b;
        e.res = {1'b0, m_a} + {1'b0, m_b};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Press a key: strobe high for 'hold' clocks, then settle two clocks.
    // 'late_code' replaces the scancode while the strobe is still held.
    task automatic press(input logic [7:0] code, input int hold,
                         input logic [7:0] late_code, input string tag);
        int d;
        @(negedge clk);
        scan_code = code;
        key_evt   = 1'b1;
        d = digit_of(code);
        if (d >= 0) begin
            if (!m_slot_b) m_a = 4'(d); else m_b = 4'(d);
            m_slot_b = ~m_slot_b;
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i == 0) scan_code = late_code;
        end
        key_evt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        push_exp(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_a = 0; m_b = 0; m_slot_b = 1'b0;
        @(negedge clk);
        push_exp(tag);
    endtask

    // Monitor: pops each expected item and compares it with the ports.
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            #1;
            begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (opnd_a !== e.a || opnd_b !== e.b || {carry_out, sum} !== e.res) begin
                    n_bad++;
                    $display("FAIL %s: got a=%0d b=%0d c/sum=%b expected a=%0d b=%0d c/sum=%b",
                             e.tag, opnd_a, opnd_b, {carry_out, sum}, e.a, e.b, e.res);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        push_exp("R9 reset state");

        press(8'h16, 1, 8'h16, "R1 R3 first digit 1 into A");
        press(8'h3D, 1, 8'h3D, "R1 R3 R7 second digit 7 into B, sum 8");
        press(8'h2E, 1, 8'h2E, "R3 R4 third digit 5 into A, B kept");
        press(8'h55, 1, 8'h55, "R5 plus key ignored");
        press(8'h46, 1, 8'h46, "R5 after plus digit 9 goes to B");
        press(8'h1C, 1, 8'h1C, "R6 non-digit ignored");
        press(8'h46, 1, 8'h46, "R6 after non-digit 9 goes to A");
        press(8'h46, 1, 8'h46, "R7 9+9 gives 0010 carry 1");
        press(8'h45, 4, 8'h3E, "R2 held strobe loads 0 once");
        press(8'h26, 1, 8'h26, "R2 R3 next digit 3 goes to B");
        press(8'h1E, 1, 8'h1E, "R1 digit 2 into A");
        press(8'h25, 1, 8'h25, "R1 digit 4 into B");
        press(8'h36, 1, 8'h36, "R1 digit 6 into A");
        press(8'h3E, 1, 8'h3E, "R1 R7 digit 8 into B, 6+8 carry");

        // R8: sum lags A by one clock
        @(negedge clk);
        scan_code = 8'h16; key_evt = 1'b1;
        @(negedge clk);
        key_evt = 1'b0;
        n_cmp++;
        if (opnd_a !== 4'd1 || {carry_out, sum} !== 5'd14) begin
            n_bad++;
            $display("FAIL R8 lag: got a=%0d c/sum=%b expected a=1 c/sum=01110",
                     opnd_a, {carry_out, sum});
        end
        @(negedge clk);
        n_cmp++;
        if ({carry_out, sum} !== 5'd9) begin
            n_bad++;
            $display("FAIL R8 update: got c/sum=%b expected 01001", {carry_out, sum});
        end
        m_a = 4'd1; m_slot_b = 1'b1;

        do_reset("R9 mid-run reset clears all");
        press(8'h26, 1, 8'h26, "R9 after reset first digit goes to A");

        wait (exp_q.size() == 0);
        #2;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule